// File: doc/BRIEF.md
# Lockable Power-On Configuration Register

This block holds the eight-bit setup word of a four-channel 10-bit converter. The word gives the channels their programmable bus identity. It chooses how a powered-down output behaves, and it picks which code every channel starts from after a reset. The serial front end reads and writes the word one byte at a time. Setting the lock bit closes the register to both reads and writes, and no later access can reopen it.

The stored word behaves like nonvolatile storage. Only the storage initialisation input `porN` returns it to its factory value, and a normal system reset `rstN` leaves it alone. After every release of `rstN`, the block issues one load strobe to the channel register bank, together with the start-up code for each channel. That code is all zeros, all ones, mid-scale, or the channel's own stored value.

Top module: `pwron_cfg_reg`

## Requirements
- R1: When `porN` is released, the register holds the parameter `INIT_VALUE`. `devType` shows bits 7:4 of the word and `hiZOnPowerDown` shows bit 3.
- R2: While bit 0 (the lock bit) is 0, asserting `wrEn` raises `accessAck` in the same cycle. The word takes the new byte at the next rising clock edge.
- R3: While the register is unlocked, asserting `rdEn` raises `accessAck` and puts the stored word on `rdData` in the same cycle.
- R4: Once bit 0 is 1, a write leaves the word unchanged, as seen on `devType`, `hiZOnPowerDown` and the next start-up code, and `accessAck` stays low.
- R5: Once bit 0 is 1, a read gives `rdData` = 0 and `accessAck` stays low. `rdData` is also 0 whenever `rdEn` is low.
- R6: A write whose bits 7:4 equal 1001 keeps the old identifier in bits 7:4 but still stores bits 3:0.
- R7: After each release of `rstN`, `loadStrobe` is high for exactly the cycle after the first rising edge. It stays low from then until the next reset, and `loadCodes` holds steady outside that load.
- R8: At the load, bits 2:1 choose the code for every channel: 00 gives 0x000, 01 gives 0x3FF, 10 gives 0x200, and 11 gives that channel's slice of `nvCodes`. Channel n occupies bits 10n+9:10n.
- R9: A write that sets bit 0 locks the register from the next cycle onward. A system reset does not unlock it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Storage initialisation, active low; loads `INIT_VALUE` |
| rstN | input | 1 | System reset, active low; re-arms the start-up load |
| wrEn | input | 1 | Byte write request from the serial front end |
| rdEn | input | 1 | Byte read request from the serial front end |
| wrData | input | 8 | Byte to write |
| nvCodes | input | 40 | Stored per-channel codes, 10 bits per channel |
| rdData | output | 8 | Word returned on an accepted read, else 0 |
| accessAck | output | 1 | Request accepted (register unlocked) |
| devType | output | 4 | Programmable device identifier |
| hiZOnPowerDown | output | 1 | 1: powered-down outputs float; 0: driven low-impedance |
| loadStrobe | output | 1 | One-cycle start-up load to all channels |
| loadCodes | output | 40 | Start-up code per channel |

## Verification
The bench builds two copies of the block. The first uses `INIT_VALUE` = 0x5E, so it starts unlocked and writes can walk the register through all four start-up policies, the guard on the reserved identifier and finally the lock. The second keeps the locked factory default of 0x5F and receives the same writes and reads. This shows that a register locked from storage initialisation never answers, while its fields still drive the start-up load and the pins.

// File: rtl/pwron_cfg_pkg.sv
package pwron_cfg_pkg;
  // bit positions inside the configuration word
  localparam int LOCK_BIT   = 0;
  localparam int POLICY_LSB = 1;
  localparam int HIZ_BIT    = 3;
  localparam int ID_LSB     = 4;
  localparam int LOW_W      = 4;

  typedef enum logic [1:0] {
    POL_ZERO   = 2'b00,
    POL_FULL   = 2'b01,
    POL_MID    = 2'b10,
    POL_STORED = 2'b11
  } policy_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrAccept;
    logic rdAccept;
    logic captureCodes;
  } cfgStrobes_t;
endpackage

// File: rtl/pwron_cfg_ctrl.sv
module pwron_cfg_ctrl
  import pwron_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        locked,
  output cfgStrobes_t strobes,
  output logic        accessAck,
  output logic        loadStrobe
);
  logic loadDone;

  // the first clock edge after reset release arms the load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadDone   <= 1'b0;
      loadStrobe <= 1'b0;
    end else begin
      loadDone   <= 1'b1;
      loadStrobe <= !loadDone;
    end
  end

  always_comb begin
    strobes.wrAccept     = wrEn && !locked;
    strobes.rdAccept     = rdEn && !locked;
    strobes.captureCodes = !loadDone;
    accessAck            = strobes.wrAccept || strobes.rdAccept;
  end

  // R7: the load pulse lasts one cycle
  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe);

  // R7: once the load has fired it does not repeat before the next reset
  p_no_refire_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && !loadStrobe) |=> !loadStrobe);
endmodule

// File: rtl/pwron_cfg_datapath.sv
module pwron_cfg_datapath
  import pwron_cfg_pkg::*;
#(
  parameter int            CH_COUNT    = 4,
  parameter int            CODE_W      = 10,
  parameter int            ID_W        = 4,
  parameter logic [ID_W+LOW_W-1:0] INIT_VALUE  = 8'h5F,
  parameter logic [ID_W-1:0]       RESERVED_ID = 4'b1001,
  localparam int           CFG_W       = ID_W + LOW_W,
  localparam int           BUS_W       = CH_COUNT * CODE_W
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  cfgStrobes_t      strobes,
  input  logic [CFG_W-1:0] wrData,
  input  logic [BUS_W-1:0] nvCodes,
  output logic [CFG_W-1:0] cfgValue,
  output logic [CFG_W-1:0] rdData,
  output logic [BUS_W-1:0] loadCodes,
  output logic             locked
);
  localparam logic [CODE_W-1:0] CODE_ZERO = '0;
  localparam logic [CODE_W-1:0] CODE_FULL = '1;
  localparam logic [CODE_W-1:0] CODE_MID  = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CFG_W-1:0] cfgQ;
  logic [CFG_W-1:0] cfgNext;
  logic [ID_W-1:0]  idNext;
  logic [BUS_W-1:0] codeSel;
  logic [BUS_W-1:0] codesQ;
  policy_e          policy;

  // identifier guard: the reserved value never enters the register
  always_comb begin
    idNext  = (wrData[CFG_W-1:ID_LSB] == RESERVED_ID) ? cfgQ[CFG_W-1:ID_LSB]
                                                      : wrData[CFG_W-1:ID_LSB];
    cfgNext = {idNext, wrData[LOW_W-1:0]};
  end

  // storage persists across system reset; only porN initialises it
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                 cfgQ <= INIT_VALUE;
    else if (strobes.wrAccept) cfgQ <= cfgNext;
  end

  assign policy   = policy_e'(cfgQ[POLICY_LSB +: 2]);
  assign locked   = cfgQ[LOCK_BIT];
  assign cfgValue = cfgQ;
  assign rdData   = strobes.rdAccept ? cfgQ : '0;

  // per-channel start-up code selection
  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    always_comb begin
      unique case (policy)
        POL_ZERO:   codeSel[ch*CODE_W +: CODE_W] = CODE_ZERO;
        POL_FULL:   codeSel[ch*CODE_W +: CODE_W] = CODE_FULL;
        POL_MID:    codeSel[ch*CODE_W +: CODE_W] = CODE_MID;
        POL_STORED: codeSel[ch*CODE_W +: CODE_W] = nvCodes[ch*CODE_W +: CODE_W];
        default:    codeSel[ch*CODE_W +: CODE_W] = CODE_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     codesQ <= '0;
    else if (strobes.captureCodes) codesQ <= codeSel;
  end
  assign loadCodes = codesQ;

  // R4 / R9: a locked word never changes
  p_locked_frozen_r4: assert property (@(posedge clk) disable iff (!porN)
    cfgQ[LOCK_BIT] |=> $stable(cfgQ));

  // R6: the reserved identifier never appears after an accepted write
  p_id_guard_r6: assert property (@(posedge clk) disable iff (!porN)
    (strobes.wrAccept && (INIT_VALUE[CFG_W-1:ID_LSB] != RESERVED_ID))
      |=> (cfgQ[CFG_W-1:ID_LSB] != RESERVED_ID));

  // R7: codes hold outside the capture cycle
  p_codes_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureCodes |=> $stable(codesQ));

  // R8: captured codes for the all-ones policy
  p_full_policy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureCodes && policy == POL_FULL) |=> (codesQ == '1));
endmodule

// File: rtl/pwron_cfg_reg.sv
module pwron_cfg_reg
  import pwron_cfg_pkg::*;
#(
  parameter int         CH_COUNT    = 4,
  parameter int         CODE_W      = 10,
  parameter int         ID_W        = 4,
  parameter logic [7:0] INIT_VALUE  = 8'h5F,
  parameter logic [3:0] RESERVED_ID = 4'b1001
) (
  input  logic                       clk,
  input  logic                       porN,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [7:0]                 wrData,
  input  logic [CH_COUNT*CODE_W-1:0] nvCodes,
  output logic [7:0]                 rdData,
  output logic                       accessAck,
  output logic [ID_W-1:0]            devType,
  output logic                       hiZOnPowerDown,
  output logic                       loadStrobe,
  output logic [CH_COUNT*CODE_W-1:0] loadCodes
);
  cfgStrobes_t strobes;
  logic        locked;
  logic [7:0]  cfgValue;

  pwron_cfg_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .locked     (locked),
    .strobes    (strobes),
    .accessAck  (accessAck),
    .loadStrobe (loadStrobe)
  );

  pwron_cfg_datapath #(
    .CH_COUNT    (CH_COUNT),
    .CODE_W      (CODE_W),
    .ID_W        (ID_W),
    .INIT_VALUE  (INIT_VALUE),
    .RESERVED_ID (RESERVED_ID)
  ) dpath_i (
    .clk       (clk),
    .porN      (porN),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .nvCodes   (nvCodes),
    .cfgValue  (cfgValue),
    .rdData    (rdData),
    .loadCodes (loadCodes),
    .locked    (locked)
  );

  assign devType        = cfgValue[ID_LSB +: ID_W];
  assign hiZOnPowerDown = cfgValue[HIZ_BIT];

  // R5: an unanswered read returns zero
  p_rd_zero_r5: assert property (@(posedge clk) disable iff (!porN)
    !accessAck |-> (rdData == '0));
endmodule

// File: tb/pwron_cfg_reg_tb.sv
`timescale 1ns/1ps
module pwron_cfg_reg_tb_top;
  localparam int CH = 4;
  localparam int CW = 10;
  localparam int NV = 5;

  // stimulus table: byte written, expected readback, expected policy
  localparam logic [7:0] WR_V  [NV] = '{8'h50, 8'h3A, 8'h94, 8'hC6, 8'h9E};
  localparam logic [7:0] RB_V  [NV] = '{8'h50, 8'h3A, 8'h34, 8'hC6, 8'hCE};
  localparam logic [1:0] POL_V [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b11};

  logic clk = 1'b0;
  logic porN = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [CH*CW-1:0] nvCodes = {10'h3FE, 10'h001, 10'h2AB, 10'h123};

  logic [7:0]       rdData, rdDataL;
  logic             ack, ackL, hiZ, hiZL, strobe, strobeL;
  logic [3:0]       devType, devTypeL;
  logic [CH*CW-1:0] codes, codesL;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwron_cfg_reg #(.INIT_VALUE(8'h5E)) dut_i (
    .clk(clk), .porN(porN), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .nvCodes(nvCodes), .rdData(rdData), .accessAck(ack),
    .devType(devType), .hiZOnPowerDown(hiZ), .loadStrobe(strobe),
    .loadCodes(codes));

  pwron_cfg_reg dutLock_i (
    .clk(clk), .porN(porN), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .nvCodes(nvCodes), .rdData(rdDataL), .accessAck(ackL),
    .devType(devTypeL), .hiZOnPowerDown(hiZL), .loadStrobe(strobeL),
    .loadCodes(codesL));

  function automatic logic [CW-1:0] expCode(logic [1:0] pol, int ch);
    case (pol)
      2'b00:   return 10'h000;
      2'b01:   return 10'h3FF;
      2'b10:   return 10'h200;
      default: return nvCodes[ch*CW +: CW];
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] b, logic expAck);
    @(negedge clk);
    wrEn = 1'b1; wrData = b;
    #1 chk("R2 write ack", ack, expAck);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(logic [7:0] expData, logic expAck, string tag);
    @(negedge clk);
    rdEn = 1'b1;
    #1;
    chk({tag, " data"}, rdData, expData);
    chk({tag, " ack"}, ack, expAck);
    chk("R5 locked twin read", {ackL, rdDataL}, 9'h0);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // warm reset, then check the start-up load of both copies
  task automatic warmReset(logic [1:0] pol, logic [1:0] polL);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    chk("R7 strobe low before edge", strobe, 1'b0);
    @(negedge clk);
    chk("R7 strobe high", strobe, 1'b1);
    chk("R7 twin strobe high", strobeL, 1'b1);
    for (int ch = 0; ch < CH; ch++) begin
      chk("R8 load code", codes[ch*CW +: CW], expCode(pol, ch));
      chk("R8 twin load code", codesL[ch*CW +: CW], expCode(polL, ch));
    end
    @(negedge clk);
    chk("R7 strobe single", strobe, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 no refire", {strobe, strobeL}, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    porN = 1'b1;
    // R1: initial contents and field decode
    chk("R1 devType", devType, 4'h5);
    chk("R1 hiZ", hiZ, 1'b1);
    chk("R1 twin devType", devTypeL, 4'h5);
    chk("R1 twin hiZ", hiZL, 1'b1);
    doRead(8'h5E, 1'b1, "R1 readback");
    warmReset(2'b11, 2'b11);

    // table: policies, identifier guard, readback
    for (int i = 0; i < NV; i++) begin
      doWrite(WR_V[i], 1'b1);
      doRead(RB_V[i], 1'b1, "R3 readback");
      chk("R6 devType", devType, RB_V[i][7:4]);
      chk("R2 hiZ", hiZ, RB_V[i][3]);
      warmReset(POL_V[i], 2'b11);
    end

    // R9: lock with policy 01, identifier A, low impedance
    doWrite(8'hA3, 1'b1);
    doRead(8'h00, 1'b0, "R5 locked read");
    chk("R9 devType after lock", devType, 4'hA);
    // R4: writes now ignored
    doWrite(8'h50, 1'b0);
    chk("R4 devType kept", devType, 4'hA);
    chk("R4 hiZ kept", hiZ, 1'b0);
    chk("R4 twin devType kept", devTypeL, 4'h5);
    chk("R4 twin hiZ kept", hiZL, 1'b1);
    warmReset(2'b01, 2'b11);
    // R9: still locked after system reset
    doRead(8'h00, 1'b0, "R9 locked after reset");
    doWrite(8'h04, 1'b0);
    chk("R4 devType after reset", devType, 4'hA);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule